// File: doc/BRIEF.md
# Byte-to-Word Peripheral Bus Bridge

This bridge lets an 8-bit processor bus drive a 32-bit Wishbone slave that has two word registers. A 256-byte page of the processor's 16-bit address space is given to the peripheral. Inside that page each four-byte group maps onto one slave word, and address bit 2 picks which of the two slave registers is used. Any address outside the page reads from a small synchronous boot ROM. The ROM covers the top page, which holds the reset vector.

A 32-bit write is built up in the bridge. The processor first stores bytes at offsets 1, 2 and 3 of a group. These stores only load internal lane latches. A store to offset 0 then issues one Wishbone write carrying the three latched bytes above the byte being stored.

A 32-bit read starts when the processor loads from offset 0. The bridge holds the processor's ready input low for one cycle. It then captures the upper three bytes of the returned word so that later loads from offsets 1 to 3 can return them without another bus access. Read data is selected from a registered copy of the processor address, which is frozen during the stall.

Top module: `byte_word_bridge`

## Requirements
- R1: After reset, `cpuRdy` is 1, every lane latch and the capture register hold zero, and no strobe occurs while the processor stays outside the peripheral page.
- R2: `wbStb` is 1 exactly when address bits [15:8] equal 0xFE and address bits [1:0] are 00, whether the access is a read or a write.
- R3: A processor write inside the page at offset 1, 2 or 3 of a group loads lane latch 1, 2 or 3 and does not strobe the bus. Writes outside the page leave the latches unchanged.
- R4: During a write at offset 0, `wbDatW` is {latch 3, latch 2, latch 1, `cpuDout`}, `wbWe` equals `cpuWe`, and `wbAdr` is address bit 2 zero-extended.
- R5: Lane latches keep their value after a word write, so a later offset-0 write reuses them.
- R6: A read strobe holds `cpuRdy` low for exactly the one cycle after the strobe edge. `cpuRdy` is never low for two cycles in a row.
- R7: A load from offset 0 returns bits [7:0] of the slave read data in the cycle after the stall. The selecting address copy does not change during the stall.
- R8: Two edges after a read strobe, slave read bits [31:8] are captured. Later loads from offsets 1, 2 and 3 return bits [15:8], [23:16] and [31:24] of that word, until the next offset-0 read.
- R9: Loads outside the page return `romData`. `romAddr` is the low 8 address bits.
- R10: Writes never stall the processor.
- R11: `wbCyc` is held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | Processor address |
| cpuDout | input | 8 | Processor write data |
| cpuWe | input | 1 | Processor write enable |
| cpuDin | output | 8 | Read data to the processor |
| cpuRdy | output | 1 | Ready to the processor, low during a read stall |
| romAddr | output | 8 | Boot ROM address |
| romData | input | 8 | Boot ROM data, registered one cycle after `romAddr` |
| wbCyc | output | 1 | Wishbone cycle, held at 1 |
| wbStb | output | 1 | Wishbone strobe |
| wbWe | output | 1 | Wishbone write enable |
| wbAdr | output | 2 | Wishbone word address |
| wbDatW | output | 32 | Wishbone write data |
| wbDatR | input | 32 | Wishbone read data |

## Verification
The assertions rely on two things about the processor. It holds its address and write enable steady while `cpuRdy` is low. The slave presents registered read data that is loaded on the strobe edge and kept until its next read strobe. The bench processor model meets both conditions:
- It changes the bus only at falling edges.
- It keeps the read address in place through every stall cycle.

The slave model latches its read word only when a read strobe is seen at a rising edge.

// File: rtl/bwb_pkg.sv
`timescale 1ns/1ps
package bwb_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;

  typedef struct packed {
    logic [LANES-2:0] stageLoad;
    logic             captureHold;
    logic             selPeriph;
    logic [1:0]       selOffset;
  } bwbCtlT;
endpackage

// File: rtl/bwb_ctrl.sv
`timescale 1ns/1ps
module bwb_ctrl
  import bwb_pkg::*;
#(
  parameter logic [7:0] PERIPH_PAGE = 8'hFE,
  parameter int         WB_AW       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       pageByte,
  input  logic [2:0]       wordOff,
  input  logic             cpuWe,
  output bwbCtlT           ctl,
  output logic             cpuRdy,
  output logic             wbCyc,
  output logic             wbStb,
  output logic             wbWe,
  output logic [WB_AW-1:0] wbAdr
);
  localparam int STAGES = LANES - 1;

  logic              pageHit;
  logic              aligned;
  logic              waitFlag;
  logic              captureQ;
  logic              pageHitQ;
  logic [1:0]        offQ;
  logic [STAGES-1:0] stageLoadW;

  assign pageHit = (pageByte == PERIPH_PAGE);
  assign aligned = (wordOff[1:0] == 2'd0);

  assign wbCyc  = 1'b1;
  assign wbStb  = pageHit && aligned;
  assign wbWe   = cpuWe;
  assign wbAdr  = WB_AW'(wordOff[2]);
  assign cpuRdy = !waitFlag;

  for (genvar i = 0; i < STAGES; i++) begin : g_load
    assign stageLoadW[i] = cpuWe && pageHit && (wordOff[1:0] == 2'(i + 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitFlag <= 1'b0;
      captureQ <= 1'b0;
      pageHitQ <= 1'b0;
      offQ     <= 2'd0;
    end else begin
      waitFlag <= waitFlag ? 1'b0 : (wbStb && !cpuWe);
      captureQ <= waitFlag;
      if (!waitFlag) begin
        pageHitQ <= pageHit;
        offQ     <= wordOff[1:0];
      end
    end
  end

  always_comb begin
    ctl.stageLoad   = stageLoadW;
    ctl.captureHold = captureQ;
    ctl.selPeriph   = pageHitQ;
    ctl.selOffset   = offQ;
  end

  AST_READ_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (wbStb && !cpuWe && cpuRdy) |=> !cpuRdy); // R6
  AST_STALL_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRdy |=> cpuRdy); // R6
  AST_WRITE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cpuRdy) |=> cpuRdy); // R10
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRdy |=> ($stable(ctl.selOffset) && $stable(ctl.selPeriph))); // R7
  AST_CAPTURE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRdy |=> ctl.captureHold); // R8
  AST_NO_STB_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wbStb |-> (ctl.stageLoad == '0)); // R3
endmodule

// File: rtl/bwb_datapath.sv
`timescale 1ns/1ps
module bwb_datapath
  import bwb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  bwbCtlT                   ctl,
  input  logic [BYTE_W-1:0]        cpuDout,
  input  logic [BYTE_W-1:0]        romData,
  input  logic [LANES*BYTE_W-1:0]  wbDatR,
  output logic [LANES*BYTE_W-1:0]  wbDatW,
  output logic [BYTE_W-1:0]        cpuDin
);
  localparam int STAGES = LANES - 1;

  logic [BYTE_W-1:0] stage [STAGES];
  logic [BYTE_W-1:0] holdB [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[i] <= '0;
        holdB[i] <= '0;
      end else begin
        if (ctl.stageLoad[i]) stage[i] <= cpuDout;
        if (ctl.captureHold)  holdB[i] <= wbDatR[BYTE_W*(i+1) +: BYTE_W];
      end
    end

    AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.stageLoad[i] |=> $stable(stage[i])); // R5
    AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      ctl.stageLoad[i] |=> (stage[i] == $past(cpuDout))); // R3
    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      ctl.captureHold |=> (holdB[i] == $past(wbDatR[BYTE_W*(i+1) +: BYTE_W]))); // R8
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.captureHold |=> $stable(holdB[i])); // R8
  end

  assign wbDatW = {stage[2], stage[1], stage[0], cpuDout};

  always_comb begin
    if (!ctl.selPeriph) begin
      cpuDin = romData;
    end else begin
      case (ctl.selOffset)
        2'd0:    cpuDin = wbDatR[BYTE_W-1:0];
        2'd1:    cpuDin = holdB[0];
        2'd2:    cpuDin = holdB[1];
        default: cpuDin = holdB[2];
      endcase
    end
  end
endmodule

// File: rtl/byte_word_bridge.sv
`timescale 1ns/1ps
module byte_word_bridge
  import bwb_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         ROM_AW      = 8,
  parameter int         WB_AW       = 2,
  parameter logic [7:0] PERIPH_PAGE = 8'hFE
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [BYTE_W-1:0]       cpuDout,
  input  logic                    cpuWe,
  output logic [BYTE_W-1:0]       cpuDin,
  output logic                    cpuRdy,
  output logic [ROM_AW-1:0]       romAddr,
  input  logic [BYTE_W-1:0]       romData,
  output logic                    wbCyc,
  output logic                    wbStb,
  output logic                    wbWe,
  output logic [WB_AW-1:0]        wbAdr,
  output logic [LANES*BYTE_W-1:0] wbDatW,
  input  logic [LANES*BYTE_W-1:0] wbDatR
);
  bwbCtlT ctl;

  assign romAddr = cpuAddr[ROM_AW-1:0];

  bwb_ctrl #(
    .PERIPH_PAGE(PERIPH_PAGE),
    .WB_AW      (WB_AW)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pageByte(cpuAddr[ADDR_W-1 -: 8]),
    .wordOff (cpuAddr[2:0]),
    .cpuWe   (cpuWe),
    .ctl     (ctl),
    .cpuRdy  (cpuRdy),
    .wbCyc   (wbCyc),
    .wbStb   (wbStb),
    .wbWe    (wbWe),
    .wbAdr   (wbAdr)
  );

  bwb_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .cpuDout(cpuDout),
    .romData(romData),
    .wbDatR (wbDatR),
    .wbDatW (wbDatW),
    .cpuDin (cpuDin)
  );

  AST_WRITE_LOW_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (wbStb && wbWe) |-> (wbDatW[BYTE_W-1:0] == cpuDout)); // R4
  AST_CYC_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    wbCyc); // R11
endmodule

// File: tb/byte_word_bridge_tb.sv
`timescale 1ns/1ps
module byte_word_bridge_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuDout;
  logic        cpuWe;
  logic [7:0]  cpuDin;
  logic        cpuRdy;
  logic [7:0]  romAddr;
  logic [7:0]  romData;
  logic        wbCyc, wbStb, wbWe;
  logic [1:0]  wbAdr;
  logic [31:0] wbDatW;
  logic [31:0] wbDatR;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int stbCount = 0;
  logic [31:0] slvReg [2];

  always #2 clk = ~clk;

  byte_word_bridge u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuDout(cpuDout), .cpuWe(cpuWe),
    .cpuDin(cpuDin), .cpuRdy(cpuRdy), .romAddr(romAddr), .romData(romData),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr),
    .wbDatW(wbDatW), .wbDatR(wbDatR)
  );

  always @(posedge clk) romData <= romAddr ^ 8'h5A;

  always @(posedge clk) begin
    if (wbCyc && wbStb) begin
      stbCount <= stbCount + 1;
      if (wbWe) slvReg[wbAdr[0]] <= wbDatW;
      else      wbDatR <= slvReg[wbAdr[0]];
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expStb(input logic [15:0] a);
    return (a[15:8] == 8'hFE) && (a[1:0] == 2'd0);
  endfunction

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d, output int stalls);
    cpuAddr = a; cpuDout = d; cpuWe = 1'b1;
    #1;
    chk(wbStb == expStb(a), "R2 write strobe", wbStb, expStb(a));
    if (expStb(a)) begin
      chk(wbDatW[7:0] == d && wbWe && wbAdr == {1'b0, a[2]}, "R4 write bus fields",
          {wbDatW[7:0], wbWe, wbAdr}, {d, 1'b1, 1'b0, a[2]});
    end
    @(posedge clk); @(negedge clk);
    cpuWe = 1'b0;
    stalls = cpuRdy ? 0 : 1;
    cpuAddr = 16'h0000;
  endtask

  task automatic cpuRead(input logic [15:0] a, output logic [7:0] d, output int stalls);
    cpuAddr = a; cpuWe = 1'b0;
    #1;
    chk(wbStb == expStb(a), "R2 read strobe", wbStb, expStb(a));
    @(posedge clk); @(negedge clk);
    stalls = 0;
    while (!cpuRdy && stalls < 8) begin
      stalls++;
      @(posedge clk); @(negedge clk);
    end
    d = cpuDin;
    cpuAddr = 16'h0000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int st;
    int sc;
    logic [31:0] expHold;
    slvReg[0] = 32'h0; slvReg[1] = 32'h0; wbDatR = 32'h0;
    rstN = 1'b0; cpuAddr = 16'h0000; cpuDout = 8'h00; cpuWe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R11 reset state
    chk(cpuRdy == 1'b1, "R1 ready after reset", cpuRdy, 1);
    chk(wbCyc == 1'b1, "R11 cycle held", wbCyc, 1);
    chk(stbCount == 0, "R1 no strobe outside page", stbCount, 0);
    cpuRead(16'hFE01, rd, st);
    chk(rd == 8'h00 && st == 0, "R1 capture cleared", {rd, 8'(st)}, 16'h0000);
    cpuWrite(16'hFE00, 8'hAB, st);
    chk(slvReg[0] == 32'h0000_00AB, "R1 lanes cleared", slvReg[0], 32'h0000_00AB);

    // R9 ROM window and non-page reads
    cpuRead(16'hFF10, rd, st);
    chk(rd == (8'h10 ^ 8'h5A) && st == 0, "R9 rom top page", rd, 8'h10 ^ 8'h5A);
    cpuRead(16'h1234, rd, st);
    chk(rd == (8'h34 ^ 8'h5A), "R9 rom other page", rd, 8'h34 ^ 8'h5A);
    cpuRead(16'hFFFC, rd, st);
    chk(rd == (8'hFC ^ 8'h5A), "R9 reset vector byte", rd, 8'hFC ^ 8'h5A);

    // R3 writes outside page ignored; in-page lanes do not strobe
    sc = stbCount;
    cpuWrite(16'hFD01, 8'h11, st);
    cpuWrite(16'h1203, 8'h22, st);
    cpuWrite(16'hFE05, 8'hC1, st);
    cpuWrite(16'hFE06, 8'hC2, st);
    cpuWrite(16'hFE07, 8'hC3, st);
    chk(stbCount == sc, "R3 lane writes no strobe", stbCount, sc);
    cpuWrite(16'hFE04, 8'hC0, st);
    chk(slvReg[1] == 32'hC3C2_C1C0, "R3 outside writes ignored", slvReg[1], 32'hC3C2_C1C0);
    chk(stbCount == sc + 1, "R2 one strobe per word write", stbCount, sc + 1);

    // Sweep: word writes and reads for both registers
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 16; k++) begin
        logic [31:0] w;
        logic [15:0] base;
        w = (32'h9E37_79B9 * (k + 1)) ^ (32'h0F0F_0F0F * r);
        base = 16'hFE00 + 16'(k * 8) + 16'(r * 4);
        cpuWrite(base + 16'd3, w[31:24], st);
        cpuWrite(base + 16'd2, w[23:16], st);
        cpuWrite(base + 16'd1, w[15:8], st);
        cpuWrite(base, w[7:0], st);
        chk(st == 0, "R10 write no stall", st, 0);
        chk(slvReg[r] == w, "R4 word assembled", slvReg[r], w);
        cpuRead(base, rd, st);
        chk(st == 1, "R6 one stall per read", st, 1);
        chk(rd == w[7:0], "R7 low byte", rd, w[7:0]);
        for (int b = 1; b < 4; b++) begin
          cpuRead(base + 16'(b), rd, st);
          chk(rd == w[8*b +: 8] && st == 0, "R8 captured byte", rd, w[8*b +: 8]);
        end
        cpuWrite(base, ~w[7:0], st);
        chk(slvReg[r] == {w[31:8], ~w[7:0]}, "R5 lanes retained", slvReg[r], {w[31:8], ~w[7:0]});
        slvReg[r] = w;
      end
    end

    // Sweep: every offset of the peripheral page, in order
    slvReg[0] = 32'h8765_4321;
    slvReg[1] = 32'hFEDC_BA98;
    expHold = 32'h0;
    for (int off = 0; off < 256; off++) begin
      logic [15:0] a;
      a = 16'hFE00 | 16'(off);
      cpuRead(a, rd, st);
      if (off % 4 == 0) begin
        chk(st == 1, "R6 aligned stall", st, 1);
        chk(rd == slvReg[a[2]][7:0], "R7 aligned byte", rd, slvReg[a[2]][7:0]);
        expHold = slvReg[a[2]];
      end else begin
        chk(st == 0, "R6 unaligned no stall", st, 0);
        chk(rd == expHold[8*(off%4) +: 8], "R8 held byte", rd, expHold[8*(off%4) +: 8]);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule